// File: doc/BRIEF.md
# Floating-Point Status, Control and Exception Tracker

This block holds the floating-point status/control word of a processor core and keeps its exception bookkeeping. Software writes the word through a load port. Only the implemented fields are stored. Two control outputs are decoded from the stored word: one selects truncation or round-to-nearest-even, and the other enables flush-to-zero for denormals. The arithmetic datapath itself is outside this block.

When an arithmetic operation completes, the datapath pulses `op_done` and presents five raw exception indications. The block clears the per-operation cause field and records the new causes. If anything was raised, it ORs those causes into the sticky flag field. It also checks the causes against the enable field. A small two-state machine turns an enabled cause into a one-cycle trap request that carries a fixed exception code.

The trap machine has two states:
- `ST_CALM`: no trap pending.
- `ST_RAISE`: `trap_req` is high.

Its transitions are:
- CALM→RAISE when an operation produces an enabled cause.
- RAISE→RAISE when the next operation does so again.
- RAISE→CALM otherwise.

Top module: `fpsc_unit`

## Requirements
- R1: A load stores `wr_data` ANDed with a mask of implemented bits. The implemented bits are 16..0 and 18, so the mask is 0x0005FFFF. Bits 17 and 31..19 always read as zero.
- R2: `round_trunc` is 1 exactly when the rounding field (bits 1..0) holds 2'b01 (round toward zero). The encodings 00, 10 and 11 give 0 (round to nearest even).
- R3: `flush_zero` follows the denormal bit, bit 18 of the stored word.
- R4: On a completed operation, the cause field (bits 16..12) is replaced by the raised exceptions. The bit order from low to high is inexact, underflow, overflow, divide-by-zero, invalid.
- R5: When at least one exception is raised, the causes are ORed into the sticky flags (bits 6..2). The flags use the same bit order as the causes, so cause bit 12+k maps to flag bit 2+k. Flags are never cleared by an operation.
- R6: When a new cause bit is set and its enable bit (bits 11..7, same order) is also set, `trap_req` is 1 in the cycle after the operation's clock edge. In that cycle `trap_code` is 0x120. At all other times `trap_code` is 0.
- R7: An operation with no exception clears the cause field, leaves the flags unchanged and raises no trap.
- R8: When `op_rsqrt` accompanies an operation that raised nothing, inexact is reported as the sole cause. If any other exception was raised, inexact is not added.
- R9: `trap_req` lasts one cycle per trapping operation. It stays high over consecutive cycles only while each cycle holds a new trapping operation.
- R10: A load in the same cycle as `op_done` wins: the loaded value is stored, the operation is dropped, and no trap follows.
- R11: After reset the stored word is zero, `trap_req` is 0 and both control outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Load strobe for the status/control word |
| wr_data | input | 32 | Value to load |
| op_done | input | 1 | One arithmetic operation completed this cycle |
| op_rsqrt | input | 1 | The completed operation is the reciprocal square-root approximation |
| exc_invalid | input | 1 | Invalid-operation indication |
| exc_divzero | input | 1 | Divide-by-zero indication |
| exc_overflow | input | 1 | Overflow indication |
| exc_underflow | input | 1 | Underflow indication |
| exc_inexact | input | 1 | Inexact indication |
| csr_q | output | 32 | Stored status/control word |
| round_trunc | output | 1 | 1 = truncate, 0 = round to nearest even |
| flush_zero | output | 1 | Flush denormals to zero |
| trap_req | output | 1 | One-cycle trap request |
| trap_code | output | 12 | Exception code of the trap (0x120), zero when idle |

## Verification
The bench builds the block with its default parameters: a 12-bit code field and the code value 0x120. With these defaults the exact code is visible at the port, and the field mapping can be exercised bit by bit. Every exception is raised alone. Then enabled and disabled overlaps are driven, along with back-to-back trapping operations and a load that collides with an operation. Each of these cases exercises a different path through the two trap states.

// File: rtl/fpsc_pkg.sv
package fpsc_pkg;
    localparam int REG_W     = 32;
    localparam int EXC_N     = 5;
    localparam int RM_LSB    = 0;
    localparam int RM_W      = 2;
    localparam int FLAG_LSB  = 2;
    localparam int EN_LSB    = FLAG_LSB + EXC_N;
    localparam int CAUSE_LSB = EN_LSB + EXC_N;
    localparam int DN_BIT    = 18;
    localparam logic [RM_W-1:0] RM_TO_ZERO = 2'b01;

    // bit index inside every exception group
    localparam int X_INEXACT   = 0;
    localparam int X_UNDERFLOW = 1;
    localparam int X_OVERFLOW  = 2;
    localparam int X_DIVZERO   = 3;
    localparam int X_INVALID   = 4;

    typedef logic [EXC_N-1:0] exc_vec_t;
    typedef enum logic {ST_CALM = 1'b0, ST_RAISE = 1'b1} trap_state_e;

    function automatic logic [REG_W-1:0] impl_mask();
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < CAUSE_LSB + EXC_N; i++) m[i] = 1'b1;
        m[DN_BIT] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/fpsc_exc_gather.sv
module fpsc_exc_gather
    import fpsc_pkg::*;
(
    input  logic     op_rsqrt,
    input  exc_vec_t raw,
    output exc_vec_t cause,
    output logic     any_cause
);
    always_comb begin
        cause = raw;
        // approximation op reports inexact when nothing else was raised
        if (op_rsqrt && raw == '0) cause[X_INEXACT] = 1'b1;
        any_cause = |cause;
    end

    always_comb begin
        assert_rsqrt_inexact_R8: assert (!(op_rsqrt && raw == '0) || cause == exc_vec_t'(1))
            else $error("approximation op lost its inexact cause");
    end
endmodule

// File: rtl/fpsc_ctl_decode.sv
module fpsc_ctl_decode
    import fpsc_pkg::*;
(
    input  logic [REG_W-1:0] csr,
    output logic             round_trunc,
    output logic             flush_zero
);
    always_comb begin
        round_trunc = (csr[RM_LSB +: RM_W] == RM_TO_ZERO);
        flush_zero  = csr[DN_BIT];
    end
endmodule

// File: rtl/fpsc_trap_fsm.sv
module fpsc_trap_fsm
    import fpsc_pkg::*;
#(
    parameter int              CODE_W    = 12,
    parameter logic [CODE_W-1:0] TRAP_CODE = 12'h120
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    output logic              trap_req,
    output logic [CODE_W-1:0] trap_code
);
    trap_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CALM;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CALM:  state_d = fire ? ST_RAISE : ST_CALM;
            ST_RAISE: state_d = fire ? ST_RAISE : ST_CALM;
            default:  state_d = ST_CALM;
        endcase
    end

    always_comb begin
        trap_req  = 1'b0;
        trap_code = '0;
        unique case (state_q)
            ST_CALM:  ;
            ST_RAISE: begin
                trap_req  = 1'b1;
                trap_code = TRAP_CODE;
            end
            default:  ;
        endcase
    end

    assert_pulse_follows_fire_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> $past(fire))
        else $error("trap without a trapping operation");
    assert_fire_gives_trap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (trap_req && trap_code == TRAP_CODE))
        else $error("trapping operation without request");
endmodule

// File: rtl/fpsc_unit.sv
module fpsc_unit
    import fpsc_pkg::*;
#(
    parameter int                CODE_W    = 12,
    parameter logic [CODE_W-1:0] TRAP_CODE = 12'h120
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    input  logic              op_done,
    input  logic              op_rsqrt,
    input  logic              exc_invalid,
    input  logic              exc_divzero,
    input  logic              exc_overflow,
    input  logic              exc_underflow,
    input  logic              exc_inexact,
    output logic [31:0]       csr_q,
    output logic              round_trunc,
    output logic              flush_zero,
    output logic              trap_req,
    output logic [CODE_W-1:0] trap_code
);
    localparam logic [REG_W-1:0] MASK = impl_mask();

    exc_vec_t         raw, cause;
    logic             any_cause;
    logic             do_op;
    logic             fire;
    logic [REG_W-1:0] csr_d;

    always_comb begin
        raw = '0;
        raw[X_INVALID]   = exc_invalid;
        raw[X_DIVZERO]   = exc_divzero;
        raw[X_OVERFLOW]  = exc_overflow;
        raw[X_UNDERFLOW] = exc_underflow;
        raw[X_INEXACT]   = exc_inexact;
    end

    fpsc_exc_gather u_gather (
        .op_rsqrt  (op_rsqrt),
        .raw       (raw),
        .cause     (cause),
        .any_cause (any_cause)
    );

    assign do_op = op_done && !wr_en;
    assign fire  = do_op && |(cause & csr_q[EN_LSB +: EXC_N]);

    always_comb begin
        csr_d = csr_q;
        if (wr_en) begin
            csr_d = wr_data & MASK;
        end else if (op_done) begin
            csr_d[CAUSE_LSB +: EXC_N] = cause;
            if (any_cause)
                csr_d[FLAG_LSB +: EXC_N] = csr_q[FLAG_LSB +: EXC_N] | cause;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) csr_q <= '0;
        else        csr_q <= csr_d;
    end

    fpsc_ctl_decode u_decode (
        .csr         (csr_q),
        .round_trunc (round_trunc),
        .flush_zero  (flush_zero)
    );

    fpsc_trap_fsm #(.CODE_W(CODE_W), .TRAP_CODE(TRAP_CODE)) u_trap (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .trap_req  (trap_req),
        .trap_code (trap_code)
    );

    assert_unimpl_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_q & ~MASK) == '0)
        else $error("unimplemented bit set");
    assert_trunc_after_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[1:0] == 2'b01) |=> round_trunc)
        else $error("truncation not selected");
    assert_flush_after_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (flush_zero == $past(wr_data[DN_BIT])))
        else $error("flush control mismatch");
    assert_quiet_op_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && !wr_en && !op_rsqrt && raw == '0) |=>
            (csr_q[CAUSE_LSB +: EXC_N] == '0 && !trap_req))
        else $error("quiet op left a cause or trapped");
    assert_flags_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ((csr_q[FLAG_LSB +: EXC_N] & $past(csr_q[FLAG_LSB +: EXC_N]))
                    == $past(csr_q[FLAG_LSB +: EXC_N])))
        else $error("sticky flag lost");
    assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (csr_q == ($past(wr_data) & MASK) && !trap_req))
        else $error("load lost priority");
endmodule

// File: tb/fpsc_unit_tb_top.sv
module fpsc_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        op_done = 1'b0, op_rsqrt = 1'b0;
    logic        e_v = 1'b0, e_z = 1'b0, e_o = 1'b0, e_u = 1'b0, e_i = 1'b0;
    logic [31:0] csr_q;
    logic        round_trunc, flush_zero, trap_req;
    logic [11:0] trap_code;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    fpsc_unit dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .op_done(op_done), .op_rsqrt(op_rsqrt),
        .exc_invalid(e_v), .exc_divzero(e_z), .exc_overflow(e_o),
        .exc_underflow(e_u), .exc_inexact(e_i),
        .csr_q(csr_q), .round_trunc(round_trunc), .flush_zero(flush_zero),
        .trap_req(trap_req), .trap_code(trap_code)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load(input logic [31:0] v);
        wr_en = 1'b1; wr_data = v;
        step();
        wr_en = 1'b0;
    endtask

    // exc order: {invalid, divzero, overflow, underflow, inexact}
    task automatic op(input logic [4:0] x, input logic rs);
        op_done = 1'b1; op_rsqrt = rs;
        {e_v, e_z, e_o, e_u, e_i} = x;
        step();
        op_done = 1'b0; op_rsqrt = 1'b0;
        {e_v, e_z, e_o, e_u, e_i} = 5'b0;
    endtask

    task automatic t_reset();
        chk("R11 word", csr_q, 32'h0);
        chk("R11 trap", {31'b0, trap_req}, 32'h0);
        chk("R11 ctl", {30'b0, round_trunc, flush_zero}, 32'h0);
    endtask

    task automatic t_mask();
        load(32'hFFFF_FFFF);
        chk("R1 mask", csr_q, 32'h0005_FFFF);
        chk("R3 flush on", {31'b0, flush_zero}, 32'h1);
        load(32'h0002_0000);
        chk("R1 bit17", csr_q, 32'h0);
        chk("R3 flush off", {31'b0, flush_zero}, 32'h0);
    endtask

    task automatic t_round();
        for (int k = 0; k < 4; k++) begin
            load(32'(k));
            chk("R2 round", {31'b0, round_trunc}, {31'b0, k == 1});
        end
    endtask

    task automatic t_causes();
        logic [4:0] fl;
        load(32'h0);
        fl = 5'b0;
        for (int b = 0; b < 5; b++) begin
            op(5'(1 << b), 1'b0);
            fl = fl | 5'(1 << b);
            chk("R4 cause", {27'b0, csr_q[16:12]}, 32'(1 << b));
            chk("R5 flags", {27'b0, csr_q[6:2]}, {27'b0, fl});
            chk("R6 no trap", {31'b0, trap_req}, 32'h0);
        end
    endtask

    task automatic t_quiet();
        load(32'h0001_5028);   // causes 10101, flags 01010
        op(5'b0, 1'b0);
        chk("R7 cause clr", {27'b0, csr_q[16:12]}, 32'h0);
        chk("R7 flags kept", {27'b0, csr_q[6:2]}, 32'h0A);
        chk("R7 no trap", {31'b0, trap_req}, 32'h0);
    endtask

    task automatic t_trap();
        load(32'h0000_0200);   // enable overflow (bit 9)
        op(5'b00010, 1'b0);    // underflow only: not enabled
        chk("R6 disabled", {31'b0, trap_req}, 32'h0);
        op(5'b00100, 1'b0);    // overflow
        chk("R6 trap", {31'b0, trap_req}, 32'h1);
        chk("R6 code", {20'b0, trap_code}, 32'h120);
        step();
        chk("R9 pulse end", {31'b0, trap_req}, 32'h0);
        chk("R6 code idle", {20'b0, trap_code}, 32'h0);
    endtask

    task automatic t_b2b();
        load(32'h0000_0F80);   // all enables
        op(5'b10000, 1'b0);
        chk("R9 first", {31'b0, trap_req}, 32'h1);
        op(5'b01000, 1'b0);
        chk("R9 second", {31'b0, trap_req}, 32'h1);
        op(5'b00000, 1'b0);
        chk("R9 drop", {31'b0, trap_req}, 32'h0);
    endtask

    task automatic t_rsqrt();
        load(32'h0);
        op(5'b0, 1'b1);
        chk("R8 inexact", {27'b0, csr_q[16:12]}, 32'h01);
        op(5'b10000, 1'b1);
        chk("R8 invalid only", {27'b0, csr_q[16:12]}, 32'h10);
        chk("R8 flags", {27'b0, csr_q[6:2]}, 32'h11);
        load(32'h0000_0080);   // enable inexact
        op(5'b0, 1'b1);
        chk("R8 trap", {31'b0, trap_req}, 32'h1);
    endtask

    task automatic t_prio();
        load(32'h0000_0F80);
        wr_en = 1'b1; wr_data = 32'h0000_0F81;
        op_done = 1'b1; e_v = 1'b1;
        step();
        wr_en = 1'b0; op_done = 1'b0; e_v = 1'b0;
        chk("R10 value", csr_q, 32'h0000_0F81);
        chk("R10 no trap", {31'b0, trap_req}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_mask();
        t_round();
        t_causes();
        t_quiet();
        t_trap();
        t_b2b();
        t_rsqrt();
        t_prio();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule